// File: doc/BRIEF.md
# Framed CRC-16 Generator for Command Transfers

This block computes a 16-bit cyclic redundancy check over the bytes of a single command transfer, one byte per clock, for a memory-device command protocol. A frame begins with a clear strobe, which also captures the frame kind: a scratchpad write or refresh, a scratchpad read, an authenticated page read, or a message-authentication-code (MAC) stream. The bytes then arrive on a byte-valid strobe. The block knows the layout of each frame kind. It zeroes the low address bits where a write frame calls for it, and it stops taking bytes once a read-type frame is complete.

The result is always driven in complemented form. The two bytes are also given separately, low byte first, so that a transmitter can send them in that order. A CRC-valid flag shows whether the frame that was seen allows the CRC to be sent. For writes, this means exactly a full scratchpad of data. For reads, it means the read ran through to the last byte. The command decoder, the memory array and the MAC engine sit outside this block.

Top module: `crc16_frame_gen`

## Requirements
- R1: The generator register clears to 0x0000 and takes each byte least significant bit first. For each bit, feedback = reg[0] XOR bit, reg shifts right by one, and if feedback = 1 then reg is XORed with 0xA001 (x^16 + x^15 + x^2 + 1 in reflected form). The ASCII bytes "123456789" leave the register at 0xBB3D.
- R2: `crc_out` is always the bitwise complement of the generator register. `crc_lo` = `crc_out[7:0]` is the first byte to send, and `crc_hi` = `crc_out[15:8]` is the second.
- R3: A cycle with `clr` = 1 clears the register and the byte count, and captures `frame_sel`. A byte offered in that same cycle is not taken. Changing `frame_sel` later in the frame has no effect. After reset the register is 0, the count is 0 and the frame kind is write.
- R4: For a write frame (`frame_sel` = 0), bits [2:0] of the second byte of the frame (the first address byte) enter the CRC as zero. No other frame kind masks any bit.
- R5: For a write frame, `crc_ok` = 1 exactly when 11 bytes have been taken since the clear: the command, two address bytes and 8 data bytes. Later bytes are still shifted into the CRC, and they drive `crc_ok` low again.
- R6: For a scratchpad read (`frame_sel` = 1), the frame is command, two address bytes, a status byte and 8 data bytes. `crc_ok` = 1 once all 12 bytes have been taken. Further bytes are ignored.
- R7: For an authenticated page read (`frame_sel` = 2), the frame is command, two address bytes, 32 data bytes and the trailing FFh byte. `crc_ok` = 1 once all 36 bytes have been taken. Further bytes are ignored.
- R8: For a MAC frame (`frame_sel` = 3), the 20 MAC bytes enter a cleared register with no header. `crc_ok` = 1 once all 20 bytes have been taken. Further bytes are ignored.
- R9: In a cycle with neither `clr` nor `byte_vld`, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Starts a frame: clears the register and the count, captures `frame_sel` |
| frame_sel | input | 2 | Frame kind: 0 write/refresh, 1 scratchpad read, 2 authenticated page, 3 MAC |
| byte_vld | input | 1 | `byte_in` carries a frame byte in this cycle |
| byte_in | input | 8 | Frame byte |
| crc_out | output | 16 | Complemented CRC |
| crc_lo | output | 8 | First byte to send (low half of `crc_out`) |
| crc_hi | output | 8 | Second byte to send (high half of `crc_out`) |
| crc_ok | output | 1 | The CRC may be sent for the frame seen so far |

## Verification
A standard nine-byte ASCII string checks the polynomial, the bit order and the complemented output against a known value. A write frame whose first address byte has its low bits set is compared with both the masked and the unmasked model values, which separates correct masking from none. Frames one byte short, exact and one byte long, for each frame kind, separate the exact-count rule for writes from the stop-at-end rule for reads. A `clr` that coincides with a byte, and idle gaps inside a frame, show that a clear wins over a byte and that the register holds when no byte arrives.

// File: rtl/crc16_frame_gen.sv
module crc16_frame_gen #(
  parameter int          SP_BYTES   = 8,
  parameter int          PAGE_BYTES = 32,
  parameter int          MAC_BYTES  = 20,
  parameter int          CNT_W      = 8,
  parameter logic [15:0] POLY_REF   = 16'hA001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic [1:0]  frame_sel,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  output logic [15:0] crc_out,
  output logic [7:0]  crc_lo,
  output logic [7:0]  crc_hi,
  output logic        crc_ok
);
  localparam int HDR_BYTES = 3;
  localparam int WR_LEN  = HDR_BYTES + SP_BYTES;
  localparam int RD_LEN  = HDR_BYTES + 1 + SP_BYTES;
  localparam int AP_LEN  = HDR_BYTES + PAGE_BYTES + 1;
  localparam int MAC_LEN = MAC_BYTES;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [1:0] FT_WRITE = 2'd0, FT_READ = 2'd1, FT_AUTH = 2'd2, FT_MAC = 2'd3;

  logic [15:0]      crc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       ft_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] target;
  logic [7:0]       byte_eff;
  logic             accept;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ POLY_REF;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_comb begin
    case (ft_q)
      FT_WRITE: begin limit = CNT_MAX;           target = CNT_W'(WR_LEN);  end
      FT_READ:  begin limit = CNT_W'(RD_LEN);    target = CNT_W'(RD_LEN);  end
      FT_AUTH:  begin limit = CNT_W'(AP_LEN);    target = CNT_W'(AP_LEN);  end
      default:  begin limit = CNT_W'(MAC_LEN);   target = CNT_W'(MAC_LEN); end
    endcase
  end

  assign byte_eff = (ft_q == FT_WRITE && cnt_q == CNT_W'(1)) ? {byte_in[7:3], 3'b000} : byte_in;
  assign accept   = byte_vld && !clr && (cnt_q != limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= 16'h0000;
      cnt_q <= '0;
      ft_q  <= FT_WRITE;
    end else if (clr) begin
      crc_q <= 16'h0000;
      cnt_q <= '0;
      ft_q  <= frame_sel;
    end else if (accept) begin
      crc_q <= crc_step(crc_q, byte_eff);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign crc_out = ~crc_q;
  assign crc_lo  = crc_out[7:0];
  assign crc_hi  = crc_out[15:8];
  assign crc_ok  = (cnt_q == target);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_out == 16'hFFFF) && !crc_ok);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !byte_vld) |=> $stable(crc_out) && $stable(crc_ok));

  p_read_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ft_q != FT_WRITE && crc_ok) |=> $stable(crc_out) && crc_ok);

  p_ok_needs_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_ok) |-> $past(byte_vld) && !$past(clr));
endmodule

// File: tb/tb_crc16_frame_gen.sv
module tb_crc16_frame_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [1:0]  frame_sel = 2'd0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic [15:0] crc_out;
  logic [7:0]  crc_lo, crc_hi;
  logic        crc_ok;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] mdl;
  logic [15:0] raw;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_frame_gen dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .frame_sel(frame_sel),
    .byte_vld(byte_vld), .byte_in(byte_in),
    .crc_out(crc_out), .crc_lo(crc_lo), .crc_hi(crc_hi), .crc_ok(crc_ok));

  function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ 16'hA001;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] sel);
    frame_sel = sel; clr = 1'b1;
    @(posedge clk); @(negedge clk);
    clr = 1'b0;
    mdl = 16'h0000;
  endtask

  task automatic put(input logic [7:0] b);
    byte_vld = 1'b1; byte_in = b;
    @(posedge clk); @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic t_reset;
    chk(crc_out == 16'hFFFF, "R3 reset crc", crc_out, 16'hFFFF);
    chk(crc_ok == 1'b0, "R3 reset ok", {15'd0, crc_ok}, 16'd0);
  endtask

  task automatic t_vector;
    start(2'd3);
    for (int i = 0; i < 9; i++) put(8'h31 + 8'(i));
    chk(crc_out == 16'h44C2, "R1 check string", crc_out, 16'h44C2);
    chk(crc_lo == 8'hC2 && crc_hi == 8'h44, "R2 byte order", {crc_hi, crc_lo}, 16'h44C2);
    chk(crc_ok == 1'b0, "R8 short mac", {15'd0, crc_ok}, 16'd0);
  endtask

  task automatic t_write;
    start(2'd0);
    put(8'h0F); mdl = ref_step(mdl, 8'h0F); raw = mdl;
    put(8'h1F); mdl = ref_step(mdl, 8'h18); raw = ref_step(raw, 8'h1F);
    put(8'h00); mdl = ref_step(mdl, 8'h00); raw = ref_step(raw, 8'h00);
    for (int i = 0; i < 8; i++) begin
      if (i == 7) chk(crc_ok == 1'b0, "R5 ten bytes", {15'd0, crc_ok}, 16'd0);
      put(8'hA0 + 8'(i)); mdl = ref_step(mdl, 8'hA0 + 8'(i)); raw = ref_step(raw, 8'hA0 + 8'(i));
    end
    chk(crc_out == ~mdl, "R4 masked address", crc_out, ~mdl);
    chk(crc_out != ~raw, "R4 unmasked differs", crc_out, ~raw);
    chk(crc_ok == 1'b1, "R5 exact eight data", {15'd0, crc_ok}, 16'd1);
    put(8'h55); mdl = ref_step(mdl, 8'h55);
    chk(crc_ok == 1'b0, "R5 nine data", {15'd0, crc_ok}, 16'd0);
    chk(crc_out == ~mdl, "R5 extra shifted", crc_out, ~mdl);
  endtask

  task automatic t_read;
    logic [15:0] held;
    start(2'd1);
    frame_sel = 2'd0;
    put(8'hAA); mdl = ref_step(mdl, 8'hAA);
    put(8'h1F); mdl = ref_step(mdl, 8'h1F);
    put(8'h00); mdl = ref_step(mdl, 8'h00);
    put(8'h07); mdl = ref_step(mdl, 8'h07);
    for (int i = 0; i < 8; i++) begin
      if (i == 7) chk(crc_ok == 1'b0, "R6 one short", {15'd0, crc_ok}, 16'd0);
      put(8'h11 * 8'(i)); mdl = ref_step(mdl, 8'h11 * 8'(i));
    end
    chk(crc_out == ~mdl, "R6 read crc no mask", crc_out, ~mdl);
    chk(crc_ok == 1'b1, "R6 end reached", {15'd0, crc_ok}, 16'd1);
    held = crc_out;
    put(8'h99);
    chk(crc_out == held && crc_ok, "R6 extra ignored", crc_out, held);
  endtask

  task automatic t_auth;
    logic [15:0] held;
    start(2'd2);
    put(8'hA5); mdl = ref_step(mdl, 8'hA5);
    put(8'h40); mdl = ref_step(mdl, 8'h40);
    put(8'h00); mdl = ref_step(mdl, 8'h00);
    for (int i = 0; i < 32; i++) begin put(8'(i * 7)); mdl = ref_step(mdl, 8'(i * 7)); end
    chk(crc_ok == 1'b0, "R7 before trailer", {15'd0, crc_ok}, 16'd0);
    put(8'hFF); mdl = ref_step(mdl, 8'hFF);
    chk(crc_out == ~mdl && crc_ok, "R7 page crc", crc_out, ~mdl);
    held = crc_out;
    put(8'h3C);
    chk(crc_out == held && crc_ok, "R7 extra ignored", crc_out, held);
  endtask

  task automatic t_mac;
    logic [15:0] held;
    start(2'd3);
    for (int i = 0; i < 20; i++) begin
      if (i == 19) chk(crc_ok == 1'b0, "R8 nineteen", {15'd0, crc_ok}, 16'd0);
      put(8'hC3 ^ 8'(i)); mdl = ref_step(mdl, 8'hC3 ^ 8'(i));
    end
    chk(crc_out == ~mdl && crc_ok, "R8 mac crc", crc_out, ~mdl);
    held = crc_out;
    put(8'h01);
    chk(crc_out == held && crc_ok, "R8 extra ignored", crc_out, held);
  endtask

  task automatic t_hold;
    logic [15:0] held;
    start(2'd3);
    put(8'h5A); mdl = ref_step(mdl, 8'h5A);
    held = crc_out;
    byte_in = 8'hE7;
    repeat (4) @(negedge clk);
    chk(crc_out == held, "R9 idle hold", crc_out, held);
    put(8'h12); mdl = ref_step(mdl, 8'h12);
    chk(crc_out == ~mdl, "R9 resume", crc_out, ~mdl);
  endtask

  task automatic t_clr_prio;
    frame_sel = 2'd3; clr = 1'b1; byte_vld = 1'b1; byte_in = 8'h77;
    @(posedge clk); @(negedge clk);
    clr = 1'b0; byte_vld = 1'b0;
    chk(crc_out == 16'hFFFF, "R3 clr wins", crc_out, 16'hFFFF);
    mdl = ref_step(16'h0000, 8'h3E);
    put(8'h3E);
    chk(crc_out == ~mdl, "R3 fresh start", crc_out, ~mdl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vector();
    t_write();
    t_read();
    t_auth();
    t_mac();
    t_hold();
    t_clr_prio();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule